// File: doc/BRIEF.md
# Adaptive-Timeout Processor Watchdog

This block watches a service strobe driven by a processor and asks the reset generator for a reset pulse when the strobe stops moving. The strobe arrives already resolved into a logic level and a separate flag that says the pin is floating. A floating strobe turns the watchdog off. Every real level change of the strobe restarts the timeout count. The count advances only on a timebase tick. Two periods are available: a short one and a long one, chosen by a select input. After any reset, the long period always applies, so that software has time to start up. The selected period applies only once a strobe transition has been seen with reset released.

On expiry the block raises a one-cycle timeout request and drops its active-low fault output. The fault output stays low until the strobe moves again while reset is released. A low-line condition forces the fault output high, and so does a floating strobe. In battery mode the fault output reads high and counting stops. The end-of-reset strobe restarts the count. If the strobe never moves, requests repeat once per long period.

The control is a four-state machine:
- `ST_GRACE`: long period, waiting for the first service edge.
- `ST_RUN`: the selected period.
- `ST_HELD`: reset asserted, counting suspended.
- `ST_OFF`: strobe floating.

Transitions:
- Any state to `ST_OFF` when the strobe floats. This has the highest priority.
- Any state other than `ST_OFF` to `ST_HELD` when reset is asserted.
- `ST_OFF` to `ST_HELD` or to `ST_GRACE` when the strobe is driven again, depending on whether reset is asserted.
- `ST_HELD` to `ST_GRACE` when reset releases.
- `ST_GRACE` to `ST_RUN` on a service edge.

Top module: `wdg_adaptive`

## Requirements
- R1: After `rst_n` deasserts, `fault_n_o` is 1, `tmo_req_o` is 0, and the long period is in force.
- R2: In `ST_RUN`, the period is SHORT_TICKS ticks when `short_sel_i`=1 and LONG_TICKS ticks when `short_sel_i`=0.
- R3: After `rst_n` and after every `sys_rst_i` assertion, the period is LONG_TICKS ticks, whatever `short_sel_i` says. This holds until the first strobe transition seen with `sys_rst_i`=0.
- R4: A strobe transition is a change of `strobe_lvl_i` between two consecutive cycles in which `strobe_flt_i`=0. A transition clears the count. A transition in the same cycle as the expiring tick wins, and no request is made.
- R5: `tmo_req_o` is a one-cycle pulse, combinational in the cycle of the tick on which the count reaches the period. `fault_n_o` goes low on the following clock edge.
- R6: `fault_n_o` stays low until a strobe transition with `sys_rst_i`=0. Transitions while `sys_rst_i`=1 are ignored. They neither clear the fault nor count as the first service edge.
- R7: While `strobe_flt_i`=1, no request is made, `fault_n_o` is 1 and the count is cleared. Entering or leaving the floating state is not a transition. On leaving it, the long period applies.
- R8: While `lowline_i`=1, `fault_n_o` is 1 in the same cycle, and a stored fault is cleared.
- R9: While `batt_i`=1, `fault_n_o` is 1, no request is made and counting is frozen. Counting resumes from the frozen value.
- R10: `rst_done_i`=1 clears the count. While `sys_rst_i`=1, counting is suspended. With a silent strobe, requests repeat every LONG_TICKS ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Timebase tick, one cycle wide |
| strobe_lvl_i | input | 1 | Resolved logic level of the service strobe |
| strobe_flt_i | input | 1 | 1 when the strobe is at the floating mid level |
| short_sel_i | input | 1 | 1 selects the short period in `ST_RUN` |
| sys_rst_i | input | 1 | 1 while the system reset is asserted |
| lowline_i | input | 1 | 1 while supply is below the low-line threshold |
| rst_done_i | input | 1 | One-cycle strobe at the end of a reset |
| batt_i | input | 1 | 1 while running from the backup battery |
| fault_n_o | output | 1 | Active-low watchdog fault |
| tmo_req_o | output | 1 | One-cycle timeout request to the reset generator |

## Verification
The bench builds the block with SHORT_TICKS=8 and LONG_TICKS=32, with a tick on almost every cycle. This puts repeated expiries, the grace period after each kind of reset and the frozen count in battery mode within a few hundred cycles. The scoreboard holds per-cycle expectations for the request and the fault output. These cover the boundary where a service edge meets the expiring tick. They also cover the difference between an 8-tick and a 32-tick period after a reset.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
    typedef enum logic [1:0] {
        ST_GRACE = 2'd0,
        ST_RUN   = 2'd1,
        ST_HELD  = 2'd2,
        ST_OFF   = 2'd3
    } wdg_state_e;
endpackage

// File: rtl/wdg_strobe_edge.sv
// Registers the previous strobe state and flags a real level change.
// A cycle touching the floating state never counts as a change.
module wdg_strobe_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    input  logic flt_i,
    output logic xition_o
);
    logic prev_lvl_q;
    logic prev_flt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_lvl_q <= 1'b0;
            prev_flt_q <= 1'b1;
        end else begin
            prev_lvl_q <= lvl_i;
            prev_flt_q <= flt_i;
        end
    end

    assign xition_o = !flt_i && !prev_flt_q && (lvl_i != prev_lvl_q);
endmodule

// File: rtl/wdg_mode_fsm.sv
// Mode state machine: grace, run, held in reset, off while floating.
module wdg_mode_fsm
    import wdg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic flt_i,
    input  logic sys_rst_i,
    input  logic svc_i,
    output logic use_long_o,
    output logic count_en_o
);
    wdg_state_e state_q;
    wdg_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (flt_i)          state_d = ST_OFF;
                else if (sys_rst_i) state_d = ST_HELD;
                else                state_d = ST_GRACE;
            end
            ST_HELD: begin
                if (flt_i)          state_d = ST_OFF;
                else if (sys_rst_i) state_d = ST_HELD;
                else                state_d = ST_GRACE;
            end
            ST_GRACE: begin
                if (flt_i)          state_d = ST_OFF;
                else if (sys_rst_i) state_d = ST_HELD;
                else if (svc_i)     state_d = ST_RUN;
                else                state_d = ST_GRACE;
            end
            ST_RUN: begin
                if (flt_i)          state_d = ST_OFF;
                else if (sys_rst_i) state_d = ST_HELD;
                else                state_d = ST_RUN;
            end
            default: state_d = ST_GRACE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_GRACE;
        else        state_q <= state_d;
    end

    always_comb begin
        use_long_o = 1'b1;
        count_en_o = 1'b0;
        unique case (state_q)
            ST_GRACE: begin use_long_o = 1'b1; count_en_o = 1'b1; end
            ST_RUN:   begin use_long_o = 1'b0; count_en_o = 1'b1; end
            ST_HELD:  begin use_long_o = 1'b1; count_en_o = 1'b0; end
            ST_OFF:   begin use_long_o = 1'b1; count_en_o = 1'b0; end
            default:  begin use_long_o = 1'b1; count_en_o = 1'b0; end
        endcase
    end
endmodule

// File: rtl/wdg_tick_counter.sv
// Tick counter with a run-time limit.
// The compare uses >= so that a switch to the shorter period while
// the count is already past it still expires on the next tick.
module wdg_tick_counter #(
    parameter int SHORT_TICKS = 1024,
    parameter int LONG_TICKS  = 4096,
    localparam int CNT_W = $clog2(LONG_TICKS)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic run_i,
    input  logic tick_i,
    input  logic sel_long_i,
    input  logic short_sel_i,
    output logic expire_o
);
    localparam logic [CNT_W-1:0] LIM_SHORT = CNT_W'(SHORT_TICKS - 1);
    localparam logic [CNT_W-1:0] LIM_LONG  = CNT_W'(LONG_TICKS - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;

    always_comb begin
        if (sel_long_i || !short_sel_i) limit = LIM_LONG;
        else                            limit = LIM_SHORT;
    end

    assign expire_o = run_i && tick_i && !clear_i && (cnt_q >= limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                cnt_q <= '0;
        else if (clear_i)          cnt_q <= '0;
        else if (run_i && tick_i)  cnt_q <= expire_o ? '0 : cnt_q + 1'b1;
    end
endmodule

// File: rtl/wdg_fault_flag.sv
// Sticky fault: set by expiry, cleared by service, low-line or floating.
module wdg_fault_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic release_i,
    input  logic trip_i,
    output logic ok_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         ok_o <= 1'b1;
        else if (release_i) ok_o <= 1'b1;
        else if (trip_i)    ok_o <= 1'b0;
    end
endmodule

// File: rtl/wdg_adaptive.sv
module wdg_adaptive #(
    parameter int SHORT_TICKS = 1024,
    parameter int LONG_TICKS  = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic strobe_lvl_i,
    input  logic strobe_flt_i,
    input  logic short_sel_i,
    input  logic sys_rst_i,
    input  logic lowline_i,
    input  logic rst_done_i,
    input  logic batt_i,
    output logic fault_n_o,
    output logic tmo_req_o
);
    logic xition;
    logic svc;
    logic use_long;
    logic count_en;
    logic expire;
    logic ok;
    logic cnt_clear;
    logic cnt_run;

    wdg_strobe_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvl_i    (strobe_lvl_i),
        .flt_i    (strobe_flt_i),
        .xition_o (xition)
    );

    // Service edges count only while reset is released (R6)
    assign svc = xition && !sys_rst_i;

    wdg_mode_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .flt_i      (strobe_flt_i),
        .sys_rst_i  (sys_rst_i),
        .svc_i      (svc),
        .use_long_o (use_long),
        .count_en_o (count_en)
    );

    assign cnt_clear = strobe_flt_i || rst_done_i || svc;
    assign cnt_run   = count_en && !batt_i && !sys_rst_i;

    wdg_tick_counter #(
        .SHORT_TICKS (SHORT_TICKS),
        .LONG_TICKS  (LONG_TICKS)
    ) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_i     (cnt_clear),
        .run_i       (cnt_run),
        .tick_i      (tick_i),
        .sel_long_i  (use_long),
        .short_sel_i (short_sel_i),
        .expire_o    (expire)
    );

    wdg_fault_flag u_fault (
        .clk       (clk),
        .rst_n     (rst_n),
        .release_i (lowline_i || strobe_flt_i || svc),
        .trip_i    (expire),
        .ok_o      (ok)
    );

    assign tmo_req_o = expire;
    assign fault_n_o = ok || lowline_i || strobe_flt_i || batt_i;
endmodule

// File: rtl/wdg_adaptive_chk.sv
module wdg_adaptive_chk (
    input logic clk,
    input logic rst_n,
    input logic strobe_flt_i,
    input logic sys_rst_i,
    input logic lowline_i,
    input logic batt_i,
    input logic fault_n_o,
    input logic tmo_req_o
);
    AST_TMO_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_req_o |=> !tmo_req_o);  // R5

    AST_FLOAT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_flt_i |-> (!tmo_req_o && fault_n_o));  // R7

    AST_LOWLINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        lowline_i |-> fault_n_o);  // R8

    AST_BATT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        batt_i |-> (fault_n_o && !tmo_req_o));  // R9

    AST_HELD_NO_TMO: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_rst_i && $past(sys_rst_i)) |-> !tmo_req_o);  // R10

    AST_FAULT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fault_n_o) |-> ($past(tmo_req_o) || $past(batt_i)));  // R6
endmodule

bind wdg_adaptive wdg_adaptive_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .strobe_flt_i (strobe_flt_i),
    .sys_rst_i    (sys_rst_i),
    .lowline_i    (lowline_i),
    .batt_i       (batt_i),
    .fault_n_o    (fault_n_o),
    .tmo_req_o    (tmo_req_o)
);

// File: tb/wdg_adaptive_tb.sv
module wdg_adaptive_tb;
    localparam int SHORT = 8;
    localparam int LONG  = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0, lvl = 1'b0, flt = 1'b0, ssel = 1'b1;
    logic srst = 1'b0, lowl = 1'b0, rdone = 1'b0, batt = 1'b0;
    logic fault_n, tmo;

    int checks = 0;
    int failures = 0;
    logic timed_out = 1'b0;

    typedef struct {
        logic  tmo;
        logic  fault;
        string tag;
    } exp_t;
    exp_t sb[$];

    always #10 clk = ~clk;

    wdg_adaptive #(.SHORT_TICKS(SHORT), .LONG_TICKS(LONG)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_i       (tick),
        .strobe_lvl_i (lvl),
        .strobe_flt_i (flt),
        .short_sel_i  (ssel),
        .sys_rst_i    (srst),
        .lowline_i    (lowl),
        .rst_done_i   (rdone),
        .batt_i       (batt),
        .fault_n_o    (fault_n),
        .tmo_req_o    (tmo)
    );

    // Monitor: 5 ns after each falling edge, ahead of the next rising edge
    initial begin
        forever begin
            @(negedge clk);
            #5;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (tmo !== e.tmo || fault_n !== e.fault) begin
                    failures++;
                    $display("FAIL %s: tmo=%0b fault_n=%0b expected tmo=%0b fault_n=%0b",
                             e.tag, tmo, fault_n, e.tmo, e.fault);
                end
            end
        end
    end

    // Driver: inputs are already set for this cycle; queue the expectation
    task automatic cyc(input logic et, input logic ef, input string tag);
        exp_t e;
        e.tmo = et;
        e.fault = ef;
        e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
    endtask

    task automatic quiet(input int n, input logic ef, input string tag);
        for (int i = 0; i < n; i++) cyc(1'b0, ef, tag);
    endtask

    task automatic stimulus();
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        cyc(0, 1, "R1 reset state");
        cyc(0, 1, "R1 reset state");

        // Grace period from power-on reset, short select ignored
        tick = 1'b1;
        quiet(LONG - 1, 1, "R3 grace after rst_n");
        cyc(1, 1, "R3 long period expiry");
        quiet(LONG - 1, 0, "R5 fault low after expiry");
        cyc(1, 0, "R10 repeat every long period");

        // System reset with an ignored strobe edge
        srst = 1'b1;
        cyc(0, 0, "R10 suspended in reset");
        cyc(0, 0, "R10 suspended in reset");
        lvl = 1'b1;
        cyc(0, 0, "R6 edge in reset ignored");
        quiet(2, 0, "R6 edge in reset ignored");
        srst = 1'b0;
        rdone = 1'b1;
        cyc(0, 0, "R6 end of reset");
        rdone = 1'b0;

        // First service edge, then restart by end-of-reset strobe
        lvl = 1'b0;
        cyc(0, 0, "R6 fault until service edge");
        quiet(5, 1, "R6 fault cleared by edge");
        rdone = 1'b1;
        cyc(0, 1, "R10 end-of-reset restart");
        rdone = 1'b0;
        quiet(SHORT - 1, 1, "R2 short period");
        cyc(1, 1, "R2 short period expiry");

        tick = 1'b0;
        cyc(0, 0, "R5 sticky fault");
        lvl = 1'b1;
        cyc(0, 0, "R6 clearing edge");
        tick = 1'b1;

        // Edge on the expiring tick wins
        for (int k = 0; k < 3; k++) begin
            quiet(SHORT - 1, 1, "R4 service keeps timer quiet");
            lvl = ~lvl;
            cyc(0, 1, "R4 edge on expiring tick");
        end

        // Long period selected in run state
        ssel = 1'b0;
        quiet(LONG - 1, 1, "R2 long select");
        cyc(1, 1, "R2 long select expiry");

        // Grace after a system reset with short selected
        ssel = 1'b1;
        srst = 1'b1;
        cyc(0, 0, "R10 held");
        cyc(0, 0, "R10 held");
        srst = 1'b0;
        rdone = 1'b1;
        cyc(0, 0, "R3 reset release");
        rdone = 1'b0;
        quiet(LONG - 1, 0, "R3 grace after system reset");
        cyc(1, 0, "R3 grace expiry");

        // Floating strobe disables the watchdog
        flt = 1'b1;
        cyc(0, 1, "R7 float forces high");
        lvl = ~lvl;
        quiet(2 * LONG, 1, "R7 float no request");
        flt = 1'b0;
        cyc(0, 1, "R7 leave float");
        quiet(LONG - 1, 1, "R7 long period after float");
        cyc(1, 1, "R7 long period after float expiry");

        // Low-line forces the fault high and clears it
        lowl = 1'b1;
        quiet(3, 1, "R8 lowline forces high");
        lowl = 1'b0;
        cyc(0, 1, "R8 stored fault cleared");

        // Battery mode freezes the count (count now 4)
        batt = 1'b1;
        quiet(2 * LONG, 1, "R9 battery mode");
        batt = 1'b0;
        quiet(LONG - 5, 1, "R9 count resumes");
        cyc(1, 1, "R9 resumed expiry");
        @(negedge clk);
    endtask

    initial begin
        fork
            stimulus();
            begin
                repeat (20000) @(posedge clk);
                timed_out = 1'b1;
            end
        join_any
        disable fork;
        #8;
        if (timed_out) begin
            checks++;
            failures++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule